// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Error Detection

This block turns an asynchronous serial line into parallel characters for a 16550-style serial port. It oversamples the line with a 16x sampling enable. At build time that enable is either a pulse supplied by the shared baud generator or the rising edges of a separate receive clock pin, which is synchronized into the core clock domain. The character format comes from the same line-control fields that the transmitter uses: a word length of 5 to 8 bits, parity on or off, even or odd parity, and stick parity. It can change from one character to the next.

Each completed character appears for one cycle on a valid strobe. The strobe carries the received bits and three per-character flags: parity error, framing error and break. The core also keeps a data-ready flag and an overrun flag, and a read pulse from the host clears both. A falling edge that is gone by mid-bit is discarded. After a framing error the receiver goes back to hunting at once. After a break it waits for the line to return high.

Top module: `uart_rx_core`

## Requirements
- R1: With EXT_RCLK = 0 every cycle with `tick16_int` high is one sampling tick. With EXT_RCLK = 1 every rising edge of `rclk_ext`, after synchronization, is one tick, and two ticks are never back to back. Both variants deliver the same characters.
- R2: A low line seen on a tick while hunting starts a candidate start bit. The line is sampled again 8 ticks later. If it is high at that point, the candidate is dropped, no character is delivered and hunting resumes.
- R3: Data bits are sampled every 16 ticks after the start confirmation, least significant bit first. `wlen` 0, 1, 2 and 3 select 5, 6, 7 and 8 bits. `rx_data` bits above the word length read 0.
- R4: With `par_en` = 1, one parity bit follows the data. The expected value is `~par_even` when `par_stick` = 1. Otherwise it is the XOR of the data bits when `par_even` = 1, and the inverse of that XOR when `par_even` = 0. `rx_perr` is 1 when the received bit differs from the expected value. With `par_en` = 0 no parity bit is taken and `rx_perr` is 0.
- R5: The first stop position is sampled 16 ticks after the last data or parity bit. If it reads 0, the character is delivered with `rx_ferr` = 1 and the receiver returns to hunting immediately, so it can recover on a later character.
- R6: If every sample from the start bit through the stop position reads 0, the character is delivered with `rx_brk` = 1, `rx_ferr` = 1 and data 0. No new start bit is accepted until the line has been seen high on a tick.
- R7: `rx_valid` is high for exactly one cycle per character. `rx_data`, `rx_perr`, `rx_ferr` and `rx_brk` belong to that character and hold until the next one.
- R8: `rx_ready` is 1 in the cycle `rx_valid` is high. A `rd_ack` pulse with no new character in the same cycle clears it in the next cycle.
- R9: A character that completes while `rx_ready` = 1 and `rd_ack` is low sets `rx_overrun`. The new character replaces the held one. `rd_ack` clears `rx_overrun`.
- R10: After reset `rx_valid`, `rx_ready`, `rx_overrun`, the three error flags and `rx_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16_int | input | 1 | 16x sampling enable from the baud generator (used when EXT_RCLK = 0) |
| rclk_ext | input | 1 | External 16x receive clock, sampled (used when EXT_RCLK = 1) |
| rxd | input | 1 | Serial input, idle high |
| wlen | input | 2 | Word length select, 5 + wlen bits |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Stick parity select |
| rd_ack | input | 1 | Host has taken the held character |
| rx_valid | output | 1 | One-cycle strobe for a completed character |
| rx_data | output | 8 | Held character, upper bits zero for short words |
| rx_perr | output | 1 | Parity error of the held character |
| rx_ferr | output | 1 | Framing error of the held character |
| rx_brk | output | 1 | Break indication of the held character |
| rx_ready | output | 1 | Data ready |
| rx_overrun | output | 1 | A character was replaced before it was read |

## Verification
The hardest condition to reach from the ports is the state after a break, where the line stays low past the stop position. A receiver that skipped the wait-for-high state would quietly start a second all-zero character there. The stimulus holds the line low for three more bit times after a full low frame, then requires exactly one delivered character, and then a clean character after the line recovers. False starts are driven as low pulses shorter than half a bit, and framing errors as a zero stop bit followed by idle time. Both are followed by a good frame, which proves that hunting resumed.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP  = 3'd4,
    S_WAITH = 3'd5
  } rx_st_t;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       brk;
  } rx_char_t;

  // Index of the last data bit for a word length code (5..8 bits).
  function automatic logic [2:0] last_bit_idx(input logic [1:0] wl);
    return 3'd4 + {1'b0, wl};
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= {STAGES{RST_VAL}};
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/rx_tick_sel.sv
module rx_tick_sel #(
  parameter bit EXT_RCLK    = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_int,
  input  logic rclk_ext,
  output logic tick
);
  generate
    if (EXT_RCLK) begin : g_ext
      logic rclk_s, rclk_d;
      logic unused_tick_int;
      assign unused_tick_int = tick_int;

      rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rclk_sync (
        .clk(clk), .rst_n(rst_n), .d(rclk_ext), .q(rclk_s)
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rclk_d <= 1'b0;
        else        rclk_d <= rclk_s;
      end

      assign tick = rclk_s & ~rclk_d;

      // R1: an edge detector can never produce two ticks in a row
      p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end else begin : g_int
      logic unused_rclk;
      assign unused_rclk = rclk_ext;
      assign tick = tick_int;
    end
  endgenerate
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  output logic       done,
  output rx_char_t   chr
);
  localparam int           CNT_W   = $clog2(OSR);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OSR - 1);

  rx_st_t           st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [2:0]       idx, idx_n;
  logic [7:0]       sh, sh_n;
  logic             pbit, pbit_n;
  logic             allz, allz_n;
  logic             exp_par;

  always_comb begin
    if (par_stick)     exp_par = ~par_even;
    else if (par_even) exp_par = ^sh;
    else               exp_par = ~(^sh);
  end

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    idx_n  = idx;
    sh_n   = sh;
    pbit_n = pbit;
    allz_n = allz;
    done   = 1'b0;
    chr    = '0;
    if (tick) begin
      unique case (st)
        S_IDLE: begin
          if (!line) begin
            st_n  = S_START;
            cnt_n = '0;
          end
        end
        S_START: begin
          if (cnt == HALF_M1) begin
            cnt_n = '0;
            if (line) begin
              st_n = S_IDLE;
            end else begin
              st_n   = S_DATA;
              idx_n  = '0;
              sh_n   = '0;
              allz_n = 1'b1;
            end
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (cnt == FULL_M1) begin
            cnt_n     = '0;
            sh_n[idx] = line;
            allz_n    = allz & ~line;
            if (idx == last_bit_idx(wlen)) st_n = par_en ? S_PAR : S_STOP;
            else                           idx_n = idx + 1'b1;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        S_PAR: begin
          if (cnt == FULL_M1) begin
            cnt_n  = '0;
            pbit_n = line;
            allz_n = allz & ~line;
            st_n   = S_STOP;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (cnt == FULL_M1) begin
            cnt_n     = '0;
            done      = 1'b1;
            chr.data  = sh;
            chr.perr  = par_en & (pbit != exp_par);
            chr.ferr  = ~line;
            chr.brk   = allz & ~line;
            st_n      = (allz & ~line) ? S_WAITH : S_IDLE;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        S_WAITH: begin
          if (line) st_n = S_IDLE;
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      idx  <= '0;
      sh   <= '0;
      pbit <= 1'b0;
      allz <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      idx  <= idx_n;
      sh   <= sh_n;
      pbit <= pbit_n;
      allz <= allz_n;
    end
  end

  // R2: a start candidate that reads high at mid-bit goes back to hunting
  p_false_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && tick && cnt == HALF_M1 && line) |=> (st == S_IDLE));

  // R6: after a break the receiver stays parked while the line is low
  p_break_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAITH && tick && !line) |=> (st == S_WAITH));

  // R7: completion is a single-cycle event
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/rx_status.sv
module rx_status
  import uart_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     done,
  input  rx_char_t chr,
  input  logic     rd_ack,
  output logic     valid,
  output rx_char_t held,
  output logic     ready,
  output logic     overrun
);
  logic     valid_n, ready_n, ovr_n;
  rx_char_t held_n;

  always_comb begin
    valid_n = done;
    held_n  = done ? chr : held;
    if (done) begin
      ready_n = 1'b1;
      ovr_n   = (overrun | ready) & ~rd_ack;
    end else if (rd_ack) begin
      ready_n = 1'b0;
      ovr_n   = 1'b0;
    end else begin
      ready_n = ready;
      ovr_n   = overrun;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      held    <= '0;
      ready   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      valid   <= valid_n;
      held    <= held_n;
      ready   <= ready_n;
      overrun <= ovr_n;
    end
  end

  // R8: data-ready is up whenever a character is announced
  p_ready_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ready);

  // R8: a read with no new arrival empties the holding state
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !done) |=> (!ready && !overrun));

  // R9: an unread character that gets replaced raises overrun
  p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ready && !rd_ack) |=> overrun);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter bit EXT_RCLK    = 1'b0,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16_int,
  input  logic       rclk_ext,
  input  logic       rxd,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       rd_ack,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_perr,
  output logic       rx_ferr,
  output logic       rx_brk,
  output logic       rx_ready,
  output logic       rx_overrun
);
  logic     tick, line_s, done;
  rx_char_t chr, held;

  rx_tick_sel #(.EXT_RCLK(EXT_RCLK), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_int(tick16_int), .rclk_ext(rclk_ext), .tick(tick)
  );

  rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_line_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(line_s)
  );

  rx_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_s),
    .wlen(wlen), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .done(done), .chr(chr)
  );

  rx_status u_status (
    .clk(clk), .rst_n(rst_n), .done(done), .chr(chr), .rd_ack(rd_ack),
    .valid(rx_valid), .held(held), .ready(rx_ready), .overrun(rx_overrun)
  );

  assign rx_data = held.data;
  assign rx_perr = held.perr;
  assign rx_ferr = held.ferr;
  assign rx_brk  = held.brk;
endmodule

// File: tb/tb_uart_rx_core.sv
module tb_uart_rx_core;
  localparam int BITCLK = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16_int = 1'b0;
  logic rclk_ext = 1'b0;
  logic rxd = 1'b1;
  logic [1:0] wlen = 2'd3;
  logic par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic rd_ack = 1'b0;

  logic       va, ra, oa, pa, fa, ba;
  logic [7:0] da;
  logic       vb, rb, ob, pb, fb, bb;
  logic [7:0] db;

  int vecs = 0, fails = 0;
  int na = 0, nb = 0;
  logic [7:0] ca, cb;
  logic [2:0] fla, flb;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart_rx_core #(.EXT_RCLK(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .tick16_int(tick16_int), .rclk_ext(rclk_ext), .rxd(rxd),
    .wlen(wlen), .par_en(par_en), .par_even(par_even), .par_stick(par_stick), .rd_ack(rd_ack),
    .rx_valid(va), .rx_data(da), .rx_perr(pa), .rx_ferr(fa), .rx_brk(ba),
    .rx_ready(ra), .rx_overrun(oa)
  );

  uart_rx_core #(.EXT_RCLK(1'b1)) dut_x (
    .clk(clk), .rst_n(rst_n), .tick16_int(tick16_int), .rclk_ext(rclk_ext), .rxd(rxd),
    .wlen(wlen), .par_en(par_en), .par_even(par_even), .par_stick(par_stick), .rd_ack(rd_ack),
    .rx_valid(vb), .rx_data(db), .rx_perr(pb), .rx_ferr(fb), .rx_brk(bb),
    .rx_ready(rb), .rx_overrun(ob)
  );

  initial forever begin @(negedge clk); tick16_int = ~tick16_int; end
  initial forever begin @(negedge clk); rclk_ext = ~rclk_ext; end

  always @(negedge clk) begin
    if (va) begin na = na + 1; ca = da; fla = {pa, fa, ba}; end
    if (vb) begin nb = nb + 1; cb = db; flb = {pb, fb, bb}; end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nbits, input bit pe, input logic pbit, input logic stop);
    send_bit(1'b0);
    for (int i = 0; i < nbits; i++) send_bit(d[i]);
    if (pe) send_bit(pbit);
    send_bit(stop);
    repeat (2) send_bit(1'b1);
  endtask

  function automatic logic exp_par(input logic [7:0] d, input logic ev, input logic st);
    if (st) return ~ev;
    return ev ? ^d : ~(^d);
  endfunction

  task automatic check_char(input int pa0, input int pb0, input logic [7:0] d,
                            input logic [2:0] fl, input string req);
    chk(na == pa0 + 1, req, "char count", na - pa0, 1);
    chk(ca == d, req, "data", ca, d);
    chk(fla == fl, req, "flags {perr,ferr,brk}", fla, fl);
    chk(nb == pb0 + 1, "R1", "ext-clock char count", nb - pb0, 1);
    chk(cb == d && flb == fl, "R1", "ext-clock char", {flb, cb}, {fl, d});
  endtask

  task automatic ack_and_check(input string req);
    chk(ra == 1'b1 && rb == 1'b1, req, "ready before read", {ra, rb}, 2'b11);
    @(negedge clk); rd_ack = 1'b1;
    @(negedge clk); rd_ack = 1'b0;
    chk(ra == 1'b0 && rb == 1'b0, req, "ready after read", {ra, rb}, 2'b00);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p0, q0;
    logic [7:0] d, pat;
    logic ep, flip;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    chk({va, ra, oa, pa, fa, ba} == 6'b0 && da == 8'h00, "R10", "reset outputs",
        {va, ra, oa, pa, fa, ba, da}, 0);
    chk({vb, rb, ob} == 3'b0, "R10", "reset outputs ext", {vb, rb, ob}, 0);

    // R3 R4 sweep: every word length, every parity mode, several patterns
    for (int w = 0; w < 4; w++) begin
      for (int m = 0; m < 5; m++) begin
        for (int p = 0; p < 4; p++) begin
          case (p)
            0: pat = 8'h00;
            1: pat = 8'hFF;
            2: pat = 8'h5A;
            default: pat = 8'(37 * (w * 5 + m) + 11);
          endcase
          d = pat & 8'((1 << (5 + w)) - 1);
          wlen = 2'(w);
          par_en = (m != 0);
          par_even = (m == 2) || (m == 3);
          par_stick = (m >= 3);
          ep = exp_par(d, par_even, par_stick);
          flip = (p == 3) && par_en;
          p0 = na; q0 = nb;
          send_frame(pat, 5 + w, par_en, ep ^ flip, 1'b1);
          check_char(p0, q0, d, {flip, 2'b00}, flip ? "R4" : "R3");
          ack_and_check("R8");
        end
      end
    end

    wlen = 2'd3; par_en = 1'b0; par_even = 1'b0; par_stick = 1'b0;

    // R2: glitch shorter than half a bit is dropped
    p0 = na; q0 = nb;
    rxd = 1'b0; repeat (10) @(negedge clk);
    rxd = 1'b1; repeat (3 * BITCLK) @(negedge clk);
    chk(na == p0 && nb == q0, "R2", "chars after glitch", na - p0 + nb - q0, 0);
    chk(ra == 1'b0, "R2", "ready after glitch", ra, 0);
    send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b1);
    check_char(p0, q0, 8'hC3, 3'b000, "R2");
    ack_and_check("R8");

    // R5: zero stop bit, then recovery on the next character
    p0 = na; q0 = nb;
    send_frame(8'h81, 8, 1'b0, 1'b0, 1'b0);
    check_char(p0, q0, 8'h81, 3'b010, "R5");
    ack_and_check("R8");
    p0 = na; q0 = nb;
    send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b1);
    check_char(p0, q0, 8'h3C, 3'b000, "R5");
    ack_and_check("R8");

    // R6: break held well past the frame yields exactly one character
    p0 = na; q0 = nb;
    rxd = 1'b0; repeat (13 * BITCLK) @(negedge clk);
    rxd = 1'b1; repeat (2 * BITCLK) @(negedge clk);
    check_char(p0, q0, 8'h00, 3'b011, "R6");
    ack_and_check("R8");
    p0 = na; q0 = nb;
    send_frame(8'hA7, 8, 1'b0, 1'b0, 1'b1);
    check_char(p0, q0, 8'hA7, 3'b000, "R6");
    ack_and_check("R8");

    // R9: second character with the first unread
    p0 = na; q0 = nb;
    send_frame(8'h11, 8, 1'b0, 1'b0, 1'b1);
    chk(oa == 1'b0, "R9", "overrun after first", oa, 0);
    send_frame(8'h22, 8, 1'b0, 1'b0, 1'b1);
    chk(na == p0 + 2, "R9", "char count", na - p0, 2);
    chk(oa == 1'b1 && ob == 1'b1, "R9", "overrun set", {oa, ob}, 2'b11);
    chk(da == 8'h22, "R9", "data replaced", da, 8'h22);
    chk(ra == 1'b1, "R9", "ready held", ra, 1);
    @(negedge clk); rd_ack = 1'b1;
    @(negedge clk); rd_ack = 1'b0;
    chk(oa == 1'b0 && ra == 1'b0, "R9", "read clears", {oa, ra}, 2'b00);

    // R7: the held character stays after the strobe
    chk(va == 1'b0 && da == 8'h22, "R7", "held data after strobe", {va, da}, 8'h22);

    finish_run();
  end
endmodule